// File: doc/BRIEF.md
# Duplex-and-crosswise cube unit

This block raises an unsigned N-bit operand to the third power. The work is split into two combinational stages followed by one output register. The first stage forms the square of the operand with a column-duplex squarer. Each result column sums twice the products of the bit pairs that are symmetric about that column, plus the square of the middle bit when the column index is even. The second stage multiplies that 2N-bit square by the original operand with a vertical-and-crosswise column multiplier. Column k adds every bit product whose two indices sum to k. In both stages a column keeps its lowest bit as the result bit and passes the rest of its sum into the next column. The final column's carry is always zero, so the 3N-bit result never overflows.

Operands enter on a valid/ready stream and cubes leave on a second valid/ready stream. The output register holds one result. An input transfer happens on a clock edge where both in_valid and in_ready are high. in_ready is high whenever the output register is empty or its content is being taken on the same edge. While the consumer holds out_ready low with a result pending, the result and out_valid stay frozen and in_ready stays low, so an offered operand waits. With out_ready held high the unit accepts one operand per clock.

Top module: `vedic_cube`

## Requirements
- R1: One clock edge after an accepted input transfer, out_cube equals the cube of the operand as an unsigned number, zero-extended to 3N bits.
- R2: The cube of the largest operand, 2^N-1, appears in full in the 3N-bit output. No column carry is left over past the top column of either stage.
- R3: An operand of 0 gives a cube of 0, and an operand of 1 gives a cube of 1.
- R4: out_valid goes high on the clock edge that accepts an input transfer, that is, one clock after in_valid is presented with in_ready high.
- R5: While rst is high at a clock edge, the edge clears out_valid and sets out_cube to 0. The reset is synchronous.
- R6: While out_valid is high and out_ready is low, out_valid and out_cube hold their values and in_ready is low. An operand offered during the stall is taken only after out_ready returns high.
- R7: in_ready is high whenever out_valid is low or out_ready is high. With out_ready held high, operands offered on consecutive clocks each produce a cube on the following clock.
- R8: When the pending result is taken and in_valid is low on that edge, out_valid goes low after that edge.
- R9: In the 4-bit configuration, the operand 4'b1001 (9) gives the cube 729, which is 12'b001011011001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this clock |
| in_operand | input | N | Unsigned operand |
| out_valid | output | 1 | Cube result pending |
| out_ready | input | 1 | Consumer takes the result this clock |
| out_cube | output | 3N | Unsigned cube of the accepted operand |

## Verification
The bench builds two instances side by side: one with the default width of 8 and one with width 4. Both run together from one clock. Their small operand spaces let every operand, 256 values and 16 values, be streamed back to back and compared with a cube computed in the bench. Every duplex column pattern and every crosswise carry pattern is therefore exercised. The all-ones operand gives the longest carry runs and fills the top output bits. The 4-bit instance also reproduces the worked value of 9, which gives 729. Separate scenarios hold out_ready low with an operand waiting, drain the register and reset it while a result is pending, to cover the stream rules.

// File: rtl/cube_pkg.sv
`timescale 1ns/1ps
package cube_pkg;
  // Width of a column accumulator: room for the number of one-bit terms,
  // the doubling of duplex pairs and the incoming carry.
  function automatic int col_bits(input int terms);
    return $clog2(terms + 1) + 2;
  endfunction
endpackage

// File: rtl/duplex_squarer.sv
`timescale 1ns/1ps
module duplex_squarer #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  output logic [2*N-1:0] sq,
  output logic           spill
);
  import cube_pkg::*;
  localparam int W  = 2 * N;
  localparam int CW = col_bits(2 * N);

  for (genvar k = 0; k < W; k++) begin : g_col
    logic [CW-1:0] dup;
    logic [CW-1:0] cin;
    logic [CW-1:0] tot;

    // Duplex of column k: doubled symmetric pairs plus the middle bit.
    always_comb begin
      dup = '0;
      for (int i = 0; i < N; i++) begin
        for (int j = i + 1; j < N; j++) begin
          if (i + j == k) dup = dup + CW'({a[i] & a[j], 1'b0});
        end
        if (2 * i == k) dup = dup + CW'(a[i]);
      end
    end

    if (k == 0) begin : g_first
      assign cin = '0;
    end else begin : g_next
      assign cin = g_col[k-1].tot >> 1;
    end

    assign tot   = dup + cin;
    assign sq[k] = tot[0];
  end

  assign spill = |(g_col[W-1].tot >> 1);
endmodule

// File: rtl/column_multiplier.sv
`timescale 1ns/1ps
module column_multiplier #(
  parameter int NA = 16,
  parameter int NB = 8
) (
  input  logic [NA-1:0]    a,
  input  logic [NB-1:0]    b,
  output logic [NA+NB-1:0] p,
  output logic             spill
);
  import cube_pkg::*;
  localparam int W  = NA + NB;
  localparam int CW = col_bits(NA + NB);

  for (genvar k = 0; k < W; k++) begin : g_col
    logic [CW-1:0] xsum;
    logic [CW-1:0] cin;
    logic [CW-1:0] tot;

    // Vertical and crosswise products that land in column k.
    always_comb begin
      xsum = '0;
      for (int i = 0; i < NA; i++) begin
        for (int j = 0; j < NB; j++) begin
          if (i + j == k) xsum = xsum + CW'(a[i] & b[j]);
        end
      end
    end

    if (k == 0) begin : g_first
      assign cin = '0;
    end else begin : g_next
      assign cin = g_col[k-1].tot >> 1;
    end

    assign tot  = xsum + cin;
    assign p[k] = tot[0];
  end

  assign spill = |(g_col[W-1].tot >> 1);
endmodule

// File: rtl/stream_reg.sv
`timescale 1ns/1ps
module stream_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end
endmodule

// File: rtl/vedic_cube.sv
`timescale 1ns/1ps
module vedic_cube #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   in_operand,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [3*N-1:0] out_cube
);
  localparam int SQW = 2 * N;
  localparam int CBW = 3 * N;

  logic [SQW-1:0] sq_w;
  logic [CBW-1:0] cube_w;
  logic           sq_spill;
  logic           mul_spill;

  duplex_squarer #(.N(N)) sqr_i (
    .a     (in_operand),
    .sq    (sq_w),
    .spill (sq_spill)
  );

  column_multiplier #(.NA(SQW), .NB(N)) mul_i (
    .a     (sq_w),
    .b     (in_operand),
    .p     (cube_w),
    .spill (mul_spill)
  );

  stream_reg #(.W(CBW)) out_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (cube_w),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_cube)
  );
endmodule

// File: rtl/vedic_cube_chk.sv
`timescale 1ns/1ps
module vedic_cube_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   in_operand,
  input logic           out_valid,
  input logic           out_ready,
  input logic [3*N-1:0] out_cube,
  input logic [2*N-1:0] sq_val,
  input logic           sq_spill,
  input logic           mul_spill
);
  logic [2*N-1:0] ext2;
  logic [3*N-1:0] ext3;
  logic [2*N-1:0] exp_sq;
  logic [3*N-1:0] exp_cube;

  always_comb begin
    ext2     = {{N{1'b0}}, in_operand};
    ext3     = {{(2*N){1'b0}}, in_operand};
    exp_sq   = ext2 * ext2;
    exp_cube = ext3 * ext3 * ext3;
  end

  // R1: the registered result is the cube of the accepted operand
  a_r1_cube: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_cube == $past(exp_cube)));

  // R1: the intermediate square from the duplex stage
  a_r1_square: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (sq_val == exp_sq));

  // R2: neither column chain leaves a carry beyond its top column
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (!sq_spill && !mul_spill));

  // R6: a stalled result is held and no operand is taken
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cube)));

  a_r6_no_accept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: an empty register always accepts
  a_r7_empty_ready: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R8: a taken result with nothing behind it empties the register
  a_r8_drain: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind vedic_cube vedic_cube_chk #(.N(N)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_operand (in_operand),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_cube   (out_cube),
  .sq_val     (sq_w),
  .sq_spill   (sq_spill),
  .mul_spill  (mul_spill)
);

// File: tb/vedic_cube_tb_top.sv
`timescale 1ns/1ps
module vedic_cube_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        v8 = 1'b0, r8, ov8, or8 = 1'b1;
  logic [7:0]  op8 = '0;
  logic [23:0] c8;
  logic        v4 = 1'b0, r4, ov4, or4 = 1'b1;
  logic [3:0]  op4 = '0;
  logic [11:0] c4;

  vedic_cube #(.N(8)) dut_i (
    .clk(clk), .rst(rst), .in_valid(v8), .in_ready(r8), .in_operand(op8),
    .out_valid(ov8), .out_ready(or8), .out_cube(c8));

  vedic_cube #(.N(4)) dut4_i (
    .clk(clk), .rst(rst), .in_valid(v4), .in_ready(r4), .in_operand(op4),
    .out_valid(ov4), .out_ready(or4), .out_cube(c4));

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  function automatic longint cube(input longint x);
    return x * x * x;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; v8 = 1'b0; v4 = 1'b0; or8 = 1'b1; or4 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 out_valid after reset", longint'(ov8), 0);
    chk("R5 out_cube after reset", longint'(c8), 0);
    chk("R5 out_valid after reset n4", longint'(ov4), 0);
    chk("R7 in_ready when empty", longint'(r8), 1);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sweep8;
    for (int x = 0; x < 256; x++) begin
      @(negedge clk);
      if (x > 0) begin
        chk("R1 cube n8", longint'(c8), cube(x - 1));
        chk("R7 back-to-back valid", longint'(ov8), 1);
      end
      chk("R7 in_ready streaming", longint'(r8), 1);
      v8 = 1'b1; op8 = 8'(x);
    end
    @(negedge clk);
    chk("R2 max operand n8", longint'(c8), cube(255));
    v8 = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sweep4;
    for (int x = 0; x < 16; x++) begin
      @(negedge clk);
      if (x > 0) chk("R1 cube n4", longint'(c4), cube(x - 1));
      v4 = 1'b1; op4 = 4'(x);
    end
    @(negedge clk);
    chk("R2 max operand n4", longint'(c4), cube(15));
    v4 = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_small;
    @(negedge clk); v8 = 1'b1; op8 = 8'd0; v4 = 1'b1; op4 = 4'd1;
    @(negedge clk);
    chk("R3 zero operand", longint'(c8), 0);
    chk("R3 one operand n4", longint'(c4), 1);
    op8 = 8'd1; op4 = 4'd0;
    @(negedge clk);
    chk("R3 one operand", longint'(c8), 1);
    chk("R3 zero operand n4", longint'(c4), 0);
    v8 = 1'b0; v4 = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_example;
    @(negedge clk); v4 = 1'b1; op4 = 4'b1001;
    @(negedge clk);
    chk("R9 worked value 9 cubed", longint'(c4), 729);
    chk("R9 bit pattern", longint'(c4), longint'(12'b001011011001));
    v4 = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_latency;
    @(negedge clk);
    chk("R8 idle before", longint'(ov8), 0);
    v8 = 1'b1; op8 = 8'd200;
    @(negedge clk);
    chk("R4 valid one clock later", longint'(ov8), 1);
    chk("R4 value one clock later", longint'(c8), cube(200));
    v8 = 1'b0;
    @(negedge clk);
    chk("R8 drained", longint'(ov8), 0);
  endtask

  task automatic t_stall;
    @(negedge clk); v8 = 1'b1; op8 = 8'd17; or8 = 1'b1;
    @(negedge clk);
    or8 = 1'b0; op8 = 8'd33;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk("R6 valid held", longint'(ov8), 1);
      chk("R6 cube held", longint'(c8), cube(17));
      chk("R6 in_ready low", longint'(r8), 0);
    end
    or8 = 1'b1;
    @(negedge clk);
    chk("R6 waiting operand taken", longint'(c8), cube(33));
    v8 = 1'b0;
    @(negedge clk);
    chk("R8 drained after stall", longint'(ov8), 0);
  endtask

  task automatic t_midreset;
    @(negedge clk); v8 = 1'b1; op8 = 8'd5;
    @(negedge clk);
    chk("R4 pending before reset", longint'(ov8), 1);
    rst = 1'b1; v8 = 1'b0;
    @(negedge clk);
    chk("R5 cleared valid", longint'(ov8), 0);
    chk("R5 cleared cube", longint'(c8), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_sweep8();
    t_sweep4();
    t_small();
    t_example();
    t_latency();
    t_stall();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule